// File: doc/BRIEF.md
# Grouped priority interrupt controller

This block collects interrupt requests from 31 groups of four request lanes each and tells the processor which pending request matters most. Groups 0 and 1 are non-maskable. A request set on one of their lanes produces a one-cycle pulse on `nmi_o`. Groups 2 to 30 are maskable. Each maskable group holds a 3-bit priority level and a 4-bit enable mask. A resolver picks the best pending maskable group and presents its level on `level_o`, a registered output. A lower level number means a higher priority, and 7 means that nothing is pending.

Request lanes arrive as one-cycle set pulses. The capture of raw input edges or levels happens upstream. When the processor acknowledges an interrupt, the currently presented winner is latched into an accepted-group register. Software reads and writes the per-group control bytes and the accepted-group byte through a byte-wide port with combinational read data.

Top module: `grp_irq_ctrl`

## Requirements
- R1: After reset, `level_o` is 7, `nmi_o` and `ack_err_o` are 0, and every readable byte returns 0.
- R2: A maskable group competes only when the AND of its request and enable is nonzero. Among the competing groups, the one with the numerically lowest level wins.
- R3: When two competing groups share the lowest level, the lower group number wins. A competing group at level 7 never displaces the idle result, which is group 0 with level 7.
- R4: `level_o` shows the winner's level one clock after the request and control state it was resolved from. It is 7 when no group competes.
- R5: A write to offset 0 of a maskable group treats data bits 7:4 as a keep/set nibble K and bits 3:0 as a data nibble D. Each request bit becomes 1 where K=1 and D=1, keeps its value where K and D are equal-but-zero or where K=1 and D=0, and becomes 0 where K=0 and D=1.
- R6: A read at offset 0 of a maskable group returns {request, request AND enable}. A read at offset 1 returns {0, level[2:0], enable[3:0]}. A write at offset 1 loads the level from bits 6:4 and the enable from bits 3:0. Offsets 2 and 3 read as 0 and ignore writes.
- R7: For groups 0 and 1, offset 0 reads {0000, request}. A write to offset 0 clears the request bits given as 1. A write to offset 3 sets the request bits given as 1. Their enable is fixed at 4'hF.
- R8: A set pulse on any lane of group 0 or 1 drives `nmi_o` high for exactly the following cycle.
- R9: On `ack_i`, the presented winner group is latched. Reading address 0x80 returns the latched group number times 4 while that group still has an enabled request, and 0 otherwise. Other offsets at 0x80 to 0x83 read 0, and writes there are ignored.
- R10: `ack_err_o` is high for the cycle after an acknowledge whose `ack_level_i` differs from `level_o`.
- R11: A set pulse on a lane wins over a write that would clear the same bit in the same cycle.
- R12: With address bit 7 clear, bits 6:2 select the group and bits 1:0 the offset. Group numbers 31 and above read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_set_i | input | 124 | Request set pulses; lane l of group g is bit 4*g+l |
| addr_i | input | 8 | Register byte address |
| wdata_i | input | 8 | Write data |
| wr_en_i | input | 1 | Write strobe |
| rdata_o | output | 8 | Combinational read data for addr_i |
| ack_i | input | 1 | Processor acknowledge |
| ack_level_i | input | 3 | Level the processor believes it accepted |
| level_o | output | 3 | Registered best pending level |
| nmi_o | output | 1 | Non-maskable interrupt pulse |
| ack_err_o | output | 1 | Acknowledge level mismatch flag |

## Verification
The bench targets three kinds of corner case. The first is ties between groups at the same level: a design that compares with less-or-equal would hand the acknowledge to the higher-numbered group. The second is a request whose lane is set but masked off: a design that tests request alone would raise the level. The third is the four cases of the keep/set nibble rule: a design that swaps keep and clear would leave stale bits or wipe live ones. It also checks that accepted-group readback drops to zero once the latched request is cleared, because a design that stored the value at acknowledge time would keep reporting a stale vector. It checks that a same-cycle set beats a clear, because a design that ordered those two the other way would lose a request.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int LANES = 4;
  localparam int LVL_W = 3;
  localparam logic [LVL_W-1:0] LVL_IDLE = '1;
  typedef logic [LANES-1:0] lane_t;
  typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/irq_group_regs.sv
module irq_group_regs
  import irq_pkg::*;
#(
  parameter bit IS_NMI = 1'b0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  lane_t      set_i,
  input  logic       wr_i,
  input  logic [1:0] off_i,
  input  logic [7:0] wdata_i,
  output lane_t      req_o,
  output lane_t      en_o,
  output lvl_t       lvl_o
);
  lane_t req_q, req_upd;
  lane_t keep_n, data_n;

  assign keep_n = wdata_i[7:4];
  assign data_n = wdata_i[3:0];

  always_comb begin
    req_upd = req_q;
    if (wr_i) begin
      if (IS_NMI) begin
        if (off_i == 2'd0) req_upd = req_q & ~data_n;
        else if (off_i == 2'd3) req_upd = req_q | data_n;
      end else if (off_i == 2'd0) begin
        req_upd = (keep_n & data_n) | (keep_n & req_q) | (~keep_n & ~data_n & req_q);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= '0;
    else         req_q <= req_upd | set_i;
  end

  generate
    if (IS_NMI) begin : g_nmi
      assign en_o  = '1;
      assign lvl_o = '0;
    end else begin : g_lvl
      lane_t en_q;
      lvl_t  lvl_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          en_q  <= '0;
          lvl_q <= '0;
        end else if (wr_i && off_i == 2'd1) begin
          en_q  <= wdata_i[3:0];
          lvl_q <= wdata_i[4 +: LVL_W];
        end
      end
      assign en_o  = en_q;
      assign lvl_o = lvl_q;
    end
  endgenerate

  assign req_o = req_q;

  p_set_wins_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((req_o & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver
  import irq_pkg::*;
#(
  parameter int NUM_GROUPS = 31,
  parameter int FIRST_LVL  = 2,
  localparam int GW = $clog2(NUM_GROUPS)
) (
  input  logic [NUM_GROUPS-1:0][LANES-1:0] req_i,
  input  logic [NUM_GROUPS-1:0][LANES-1:0] en_i,
  input  logic [NUM_GROUPS-1:0][LVL_W-1:0] lvl_i,
  output logic [GW-1:0]                    win_o,
  output lvl_t                             lvl_o
);
  always_comb begin
    win_o = '0;
    lvl_o = LVL_IDLE;
    for (int g = FIRST_LVL; g < NUM_GROUPS; g++) begin
      if (((req_i[g] & en_i[g]) != '0) && (lvl_i[g] < lvl_o)) begin
        win_o = GW'(g);
        lvl_o = lvl_i[g];
      end
    end
  end
endmodule

// File: rtl/grp_irq_ctrl.sv
module grp_irq_ctrl
  import irq_pkg::*;
#(
  parameter int NUM_GROUPS = 31,
  parameter int NMI_GROUPS = 2,
  parameter int ADDR_W     = 8,
  localparam int GW        = $clog2(NUM_GROUPS),
  localparam int NREQ      = NUM_GROUPS * LANES,
  localparam int IDX_W     = ADDR_W - 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NREQ-1:0]   req_set_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  logic              wr_en_i,
  output logic [7:0]        rdata_o,
  input  logic              ack_i,
  input  logic [LVL_W-1:0]  ack_level_i,
  output logic [LVL_W-1:0]  level_o,
  output logic              nmi_o,
  output logic              ack_err_o
);
  logic [NUM_GROUPS-1:0][LANES-1:0] req_a, en_a;
  logic [NUM_GROUPS-1:0][LVL_W-1:0] lvl_a;
  logic [IDX_W-1:0] gidx;
  logic [1:0]       off;
  logic             acc_sel;
  logic [GW-1:0]    win_c, win_q, acc_q;
  lvl_t             lvl_c, level_q;
  logic             nmi_q, err_q;

  assign acc_sel = addr_i[ADDR_W-1];
  assign gidx    = addr_i[ADDR_W-2:2];
  assign off     = addr_i[1:0];

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    irq_group_regs #(.IS_NMI(g < NMI_GROUPS)) u_grp (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .set_i   (req_set_i[g*LANES +: LANES]),
      .wr_i    (wr_en_i && !acc_sel && (gidx == IDX_W'(g))),
      .off_i   (off),
      .wdata_i (wdata_i),
      .req_o   (req_a[g]),
      .en_o    (en_a[g]),
      .lvl_o   (lvl_a[g])
    );
  end

  irq_prio_resolver #(.NUM_GROUPS(NUM_GROUPS), .FIRST_LVL(NMI_GROUPS)) u_res (
    .req_i (req_a),
    .en_i  (en_a),
    .lvl_i (lvl_a),
    .win_o (win_c),
    .lvl_o (lvl_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q   <= '0;
      level_q <= LVL_IDLE;
      acc_q   <= '0;
      nmi_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      win_q   <= win_c;
      level_q <= lvl_c;
      nmi_q   <= |req_set_i[NMI_GROUPS*LANES-1:0];
      err_q   <= ack_i && (ack_level_i != level_q);
      if (ack_i) acc_q <= win_q;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (acc_sel) begin
      // accepted group valid only while its enabled request persists
      if (off == 2'd0 && (req_a[acc_q] & en_a[acc_q]) != '0)
        rdata_o = 8'(acc_q) << 2;
    end else if (int'(gidx) < NUM_GROUPS) begin
      if (int'(gidx) < NMI_GROUPS) begin
        if (off == 2'd0) rdata_o = {4'b0, req_a[gidx]};
      end else begin
        case (off)
          2'd0:    rdata_o = {req_a[gidx], req_a[gidx] & en_a[gidx]};
          2'd1:    rdata_o = {1'b0, lvl_a[gidx], en_a[gidx]};
          default: rdata_o = '0;
        endcase
      end
    end
  end

  assign level_o   = level_q;
  assign nmi_o     = nmi_q;
  assign ack_err_o = err_q;

  p_nmi_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|req_set_i[NMI_GROUPS*LANES-1:0]) |=> nmi_o);
  p_ack_latch_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> (acc_q == $past(win_q)));
  p_idle_level_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_o == LVL_IDLE) |-> (win_q == '0));
  p_ack_flag_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && ack_level_i != level_o) |=> ack_err_o);
endmodule

// File: tb/grp_irq_ctrl_bench.sv
`timescale 1ns/1ps
module grp_irq_ctrl_bench;
  localparam int NG = 31;
  localparam int NREQ = NG * 4;

  logic clk = 0, rst_n = 0;
  logic [NREQ-1:0] req_set = '0;
  logic [7:0] addr = '0, wdata = '0;
  logic wr = 0, ack = 0;
  logic [2:0] ack_lvl = '0;
  logic [7:0] rdata;
  logic [2:0] level;
  logic nmi, ack_err;

  int errors = 0, checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  grp_irq_ctrl u_grp_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_set_i(req_set), .addr_i(addr),
    .wdata_i(wdata), .wr_en_i(wr), .rdata_o(rdata), .ack_i(ack),
    .ack_level_i(ack_lvl), .level_o(level), .nmi_o(nmi), .ack_err_o(ack_err));

  // behavioural reference state
  int m_req[NG], m_en[NG], m_lvl[NG];
  int m_win = 0, m_level = 7, m_acc = 0, m_nmi = 0, m_err = 0;

  function automatic int m_read(int a);
    int g, o;
    if (a >= 128) begin
      if ((a & 3) == 0 && (m_req[m_acc] & m_en[m_acc]) != 0) return m_acc * 4;
      return 0;
    end
    g = a / 4; o = a % 4;
    if (g >= NG) return 0;
    if (g < 2) return (o == 0) ? m_req[g] : 0;
    if (o == 0) return m_req[g] * 16 + (m_req[g] & m_en[g]);
    if (o == 1) return m_lvl[g] * 16 + m_en[g];
    return 0;
  endfunction

  task automatic m_reset();
    for (int g = 0; g < NG; g++) begin
      m_req[g] = 0; m_en[g] = (g < 2) ? 15 : 0; m_lvl[g] = 0;
    end
    m_win = 0; m_level = 7; m_acc = 0; m_nmi = 0; m_err = 0;
  endtask

  initial m_reset();

  always @(posedge clk) begin
    if (!rst_n) m_reset();
    else begin
      int bw, bl, g, o, k, d, any_nmi;
      bw = 0; bl = 7;
      for (int i = 2; i < NG; i++)
        if ((m_req[i] & m_en[i]) != 0 && m_lvl[i] < bl) begin bw = i; bl = m_lvl[i]; end
      m_err = (ack && ack_lvl != m_level) ? 1 : 0;
      if (ack) m_acc = m_win;
      any_nmi = (req_set[7:0] != 0) ? 1 : 0;
      if (wr && addr < 128) begin
        g = addr / 4; o = addr % 4; k = wdata[7:4]; d = wdata[3:0];
        if (g < 2) begin
          if (o == 0) m_req[g] = m_req[g] & ~d & 15;
          else if (o == 3) m_req[g] = m_req[g] | d;
        end else if (g < NG) begin
          if (o == 0) m_req[g] = ((k & d) | (k & m_req[g]) | (~k & ~d & m_req[g])) & 15;
          else if (o == 1) begin m_lvl[g] = wdata[6:4]; m_en[g] = d; end
        end
      end
      for (int i = 0; i < NG; i++) m_req[i] = m_req[i] | req_set[i*4 +: 4];
      m_win = bw; m_level = bl; m_nmi = any_nmi;
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R4 level_o", level, m_level);
      check("R8 nmi_o", nmi, m_nmi);
      check("R10 ack_err_o", ack_err, m_err);
      check("R6 rdata_o", rdata, m_read(addr));
    end
  end

  task automatic cyc(); @(posedge clk); #1; endtask
  task automatic pulse(int g, int l); req_set[g*4+l] = 1'b1; cyc(); req_set = '0; endtask
  task automatic wr_b(int a, int d); addr = 8'(a); wdata = 8'(d); wr = 1; cyc(); wr = 0; endtask
  task automatic do_ack(int lv); ack = 1; ack_lvl = 3'(lv); cyc(); ack = 0; endtask
  task automatic rd_chk(int a, int exp, string tag);
    addr = 8'(a); @(negedge clk); check(tag, rdata, exp); cyc();
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    repeat (3) cyc();
    rst_n = 1; cyc();
    // R1 reset state
    check("R1 level", level, 7);
    check("R1 nmi", nmi, 0);
    rd_chk(8'h15, 0, "R1 enable reset");
    rd_chk(8'h00, 0, "R1 nmi req reset");
    rd_chk(8'h80, 0, "R1 accepted reset");
    // R2 priority by level and masking
    wr_b(8'h15, 8'h3F);
    pulse(5, 0);
    rd_chk(8'h14, 8'h11, "R6 byte0 readback");
    rd_chk(8'h15, 8'h3F, "R6 byte1 readback");
    check("R2 level 3", level, 3);
    wr_b(8'h25, 8'h21);
    pulse(9, 2); cyc();
    check("R2 masked lane", level, 3);
    pulse(9, 0); cyc();
    check("R2 lower wins", level, 2);
    // R3 tie
    wr_b(8'h31, 8'h2F);
    pulse(12, 1); cyc(); cyc();
    check("R3 tie level", level, 2);
    do_ack(2);
    check("R10 no mismatch", ack_err, 0);
    rd_chk(8'h80, 36, "R3 R9 accepted group 9");
    wr_b(8'h24, 8'h0F);
    rd_chk(8'h80, 0, "R9 lost request");
    rd_chk(8'h81, 0, "R9 other offset");
    wr_b(8'h80, 8'hFF);
    rd_chk(8'h80, 0, "R9 write ignored");
    // R5 masked write rule: req 0001, write C6 -> 0101
    wr_b(8'h14, 8'hC6);
    rd_chk(8'h14, 8'h55, "R5 nibble rule");
    // R11 set beats clear
    req_set[5*4+0] = 1'b1; wr_b(8'h14, 8'h0F); req_set = '0;
    rd_chk(8'h14, 8'h11, "R11 set wins");
    // R7 / R8 non-maskable groups
    pulse(1, 3);
    check("R8 nmi pulse", nmi, 1);
    cyc();
    check("R8 nmi one cycle", nmi, 0);
    rd_chk(8'h04, 8'h08, "R7 nmi readback");
    wr_b(8'h07, 8'h03);
    rd_chk(8'h04, 8'h0B, "R7 set via offset 3");
    wr_b(8'h04, 8'h08);
    rd_chk(8'h04, 8'h03, "R7 clear via offset 0");
    rd_chk(8'h05, 0, "R7 other offset");
    // R10 mismatch
    do_ack(5);
    check("R10 mismatch flag", ack_err, 1);
    // R12 out-of-range group
    wr_b(8'h7D, 8'h7F);
    rd_chk(8'h7D, 0, "R12 group 31 ignored");
    rd_chk(8'h7C, 0, "R12 group 31 byte0");
    // random traffic against the model
    for (int n = 0; n < 600; n++) begin
      int r;
      r = $urandom_range(0, 9);
      if (r < 3) req_set[$urandom_range(0, NREQ-1)] = 1'b1;
      if (r == 4) begin addr = 8'($urandom_range(0, 127)); wdata = 8'($urandom); wr = 1; end
      if (r == 5) begin ack = 1; ack_lvl = level; end
      if (r >= 6) addr = 8'($urandom_range(0, 131));
      cyc();
      req_set = '0; wr = 0; ack = 0;
    end
    repeat (3) cyc();
    finish_run();
  end
endmodule